// File: doc/BRIEF.md
# Frame Buffer Rectangle Copy Engine

This engine moves a rectangle of 16-bit pixels from one place to another inside a 1024 by 512 pixel frame buffer. A caller presents three 32-bit parameter words and a set-mask flag, then pulses `start`. The words give the source corner, the destination corner and the rectangle size. The engine drives a single-port pixel memory through read and write requests, and it pulses `done` once the last pixel has been written.

Each line is handled in chunks of up to 128 pixels. The engine reads every pixel of a chunk into a local line buffer before it writes any of them back. For this reason a copy whose source and destination overlap, including one where the source sits to the left of the destination, gives the same result as a chunk-by-chunk copy through a temporary store. Both axes wrap, so a rectangle that runs past the right or bottom edge continues at column 0 or row 0.

Top module: `vram_rect_copy`

## Requirements
- R1: The source corner is taken from `src_word`, with column x in bits [9:0] and row y in bits [24:16]. The destination corner is taken from `dst_word` using the same bit positions. All other bits of both words are ignored.
- R2: The width is ((`size_word`[15:0] − 1) mod 1024) + 1 and the height is ((`size_word`[31:16] − 1) mod 512) + 1. A field value of 0 therefore means a width of 1024 or a height of 512.
- R3: Every pixel address is formed as y·1024 + x on `mem_addr`. Column arithmetic wraps modulo 1024 and row arithmetic wraps modulo 512, for both the source and the destination.
- R4: With `set_mask` low, each written pixel equals the source pixel that was read. With `set_mask` high, each written pixel is the source pixel OR 0x8000.
- R5: If the source corner equals the destination corner and `set_mask` is low, the engine issues no memory request and raises `done` in the cycle right after the one in which `start` was sampled. With `set_mask` high, the same-corner copy is carried out in full.
- R6: Each line is split into chunks of min(128, remaining width) pixels. All reads of a chunk complete before its first write, so an overlapping copy matches a chunk-wise copy through a temporary store.
- R7: Lines are processed in increasing row order starting at row offset 0. Pixels are processed in increasing column order, both within a chunk and from one chunk to the next.
- R8: `start` is ignored while `busy` is high. A second request made during a copy produces neither writes nor a second `done`.
- R9: `done` is high for exactly one cycle. It rises only after the last write request of the copy, and no request is pending while it is high.
- R10: Read data is taken from `mem_rdata` one cycle after the cycle in which `mem_rd_en` is high. At most one request is issued per cycle, and a read and a write are never issued together.
- R11: After a synchronous reset, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a copy using the current parameter words |
| src_word | input | 32 | Source corner word |
| dst_word | input | 32 | Destination corner word |
| size_word | input | 32 | Rectangle size word |
| set_mask | input | 1 | Force bit 15 on every written pixel |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle pulse when a copy completes |
| mem_rd_en | output | 1 | Pixel read request |
| mem_wr_en | output | 1 | Pixel write request |
| mem_addr | output | 19 | Pixel address, row in the upper 9 bits, column in the lower 10 |
| mem_wdata | output | 16 | Pixel write data |
| mem_rdata | input | 16 | Pixel read data, valid one cycle after a read request |

## Verification
The assertions rely on the pixel memory returning read data exactly one cycle after each request and never stalling. They also rely on `start` not being raised in the same cycle that a same-corner skip raises `done`. The bench memory model answers every read with a registered lookup, and the driver leaves a gap of at least one idle cycle after each `done` before it raises `start` again. The one deliberate request made while the engine is busy comes in the middle of a long copy, well away from any `done` pulse.

// File: rtl/vrc_pkg.sv
package vrc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_RDRAIN,
    ST_WRITE,
    ST_WDRAIN
  } vrc_state_t;

endpackage

// File: rtl/vrc_pos_decode.sv
module vrc_pos_decode #(
  parameter int WORD_W = 32,
  parameter int XW     = 10,
  parameter int YW     = 9,
  parameter int Y_LSB  = 16
) (
  input  logic [WORD_W-1:0] word,
  output logic [XW-1:0]     x,
  output logic [YW-1:0]     y
);
  logic unused_bits;

  assign x = word[XW-1:0];
  assign y = word[Y_LSB +: YW];
  assign unused_bits = ^word;
endmodule

// File: rtl/vrc_size_decode.sv
module vrc_size_decode #(
  parameter int WORD_W = 32,
  parameter int XW     = 10,
  parameter int YW     = 9,
  parameter int Y_LSB  = 16
) (
  input  logic [WORD_W-1:0] word,
  output logic [XW:0]       wlen,
  output logic [YW-1:0]     hlast
);
  logic [XW-1:0] wlast;
  logic          unused_bits;

  // field minus one, truncated: zero wraps to the largest span
  assign wlast = word[XW-1:0] - XW'(1);
  assign wlen  = (XW+1)'(wlast) + (XW+1)'(1);
  assign hlast = word[Y_LSB +: YW] - YW'(1);
  assign unused_bits = ^word;
endmodule

// File: rtl/vrc_line_buf.sv
module vrc_line_buf #(
  parameter int PIX_W = 16,
  parameter int DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [PIX_W-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [PIX_W-1:0]         rdata
);
  logic [PIX_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/vram_rect_copy.sv
module vram_rect_copy import vrc_pkg::*; #(
  parameter int XW     = 10,
  parameter int YW     = 9,
  parameter int PIX_W  = 16,
  parameter int CHUNK  = 128,
  parameter int WORD_W = 32,
  parameter int Y_LSB  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WORD_W-1:0]  src_word,
  input  logic [WORD_W-1:0]  dst_word,
  input  logic [WORD_W-1:0]  size_word,
  input  logic               set_mask,
  output logic               busy,
  output logic               done,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [XW+YW-1:0]   mem_addr,
  output logic [PIX_W-1:0]   mem_wdata,
  input  logic [PIX_W-1:0]   mem_rdata
);
  localparam int AW = XW + YW;
  localparam int CW = $clog2(CHUNK);
  localparam int WW = XW + 1;
  localparam logic [PIX_W-1:0] MSB_SET = PIX_W'(1) << (PIX_W-1);

  vrc_state_t     st;
  logic [XW-1:0]  dec_sx, dec_dx, sx_q, dx_q;
  logic [YW-1:0]  dec_sy, dec_dy, sy_q, dy_q;
  logic [WW-1:0]  dec_wlen, wlen_q, xoff_q;
  logic [YW-1:0]  dec_hlast, hlast_q, row_q;
  logic           mask_q;
  logic [CW-1:0]  idx_q, clast_q, rtag_q, rtag2_q;
  logic           rvld_q, wstage_q;
  logic [AW-1:0]  waddr_q;
  logic [PIX_W-1:0] buf_q;

  vrc_pos_decode #(.WORD_W(WORD_W), .XW(XW), .YW(YW), .Y_LSB(Y_LSB)) src_dec_i (
    .word(src_word), .x(dec_sx), .y(dec_sy));
  vrc_pos_decode #(.WORD_W(WORD_W), .XW(XW), .YW(YW), .Y_LSB(Y_LSB)) dst_dec_i (
    .word(dst_word), .x(dec_dx), .y(dec_dy));
  vrc_size_decode #(.WORD_W(WORD_W), .XW(XW), .YW(YW), .Y_LSB(Y_LSB)) size_dec_i (
    .word(size_word), .wlen(dec_wlen), .hlast(dec_hlast));

  vrc_line_buf #(.PIX_W(PIX_W), .DEPTH(CHUNK)) lbuf_i (
    .clk(clk), .we(rvld_q), .waddr(rtag2_q), .wdata(mem_rdata),
    .raddr(idx_q), .rdata(buf_q));

  function automatic logic [CW-1:0] chunk_last(input logic [WW-1:0] rem);
    if (rem > WW'(CHUNK)) return CW'(CHUNK - 1);
    return CW'(rem - WW'(1));
  endfunction

  logic [XW-1:0] rd_x, wr_x;
  logic [YW-1:0] rd_y, wr_y;
  logic [WW-1:0] nxt_off;
  logic          row_end, last_row, same_place, chunk_end;

  // truncation to XW/YW bits provides the wrap on both axes
  assign rd_x       = sx_q + xoff_q[XW-1:0] + XW'(idx_q);
  assign wr_x       = dx_q + xoff_q[XW-1:0] + XW'(idx_q);
  assign rd_y       = sy_q + row_q;
  assign wr_y       = dy_q + row_q;
  assign nxt_off    = xoff_q + WW'(clast_q) + WW'(1);
  assign row_end    = nxt_off >= wlen_q;
  assign last_row   = row_q == hlast_q;
  assign chunk_end  = idx_q == clast_q;
  assign same_place = (dec_sx == dec_dx) && (dec_sy == dec_dy);
  assign busy       = st != ST_IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      sx_q <= '0; sy_q <= '0; dx_q <= '0; dy_q <= '0;
      wlen_q <= '0; hlast_q <= '0; mask_q <= 1'b0;
      row_q <= '0; xoff_q <= '0; idx_q <= '0; clast_q <= '0;
      rtag_q <= '0; rtag2_q <= '0; rvld_q <= 1'b0;
      wstage_q <= 1'b0; waddr_q <= '0;
      mem_rd_en <= 1'b0; mem_wr_en <= 1'b0;
      mem_addr <= '0; mem_wdata <= '0; done <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      wstage_q  <= 1'b0;
      done      <= 1'b0;
      rvld_q    <= mem_rd_en;
      rtag2_q   <= rtag_q;

      if (wstage_q) begin
        mem_wr_en <= 1'b1;
        mem_addr  <= waddr_q;
        mem_wdata <= mask_q ? (buf_q | MSB_SET) : buf_q;
      end

      unique case (st)
        ST_IDLE: if (start) begin
          sx_q <= dec_sx; sy_q <= dec_sy; dx_q <= dec_dx; dy_q <= dec_dy;
          wlen_q <= dec_wlen; hlast_q <= dec_hlast; mask_q <= set_mask;
          row_q <= '0; xoff_q <= '0; idx_q <= '0;
          clast_q <= chunk_last(dec_wlen);
          if (same_place && !set_mask) done <= 1'b1;
          else                         st   <= ST_READ;
        end
        ST_READ: begin
          mem_rd_en <= 1'b1;
          mem_addr  <= {rd_y, rd_x};
          rtag_q    <= idx_q;
          if (chunk_end) begin
            idx_q <= '0;
            st    <= ST_RDRAIN;
          end else begin
            idx_q <= idx_q + CW'(1);
          end
        end
        ST_RDRAIN: if (!mem_rd_en && !rvld_q) st <= ST_WRITE;
        ST_WRITE: begin
          wstage_q <= 1'b1;
          waddr_q  <= {wr_y, wr_x};
          if (chunk_end) begin
            idx_q <= '0;
            st    <= ST_WDRAIN;
          end else begin
            idx_q <= idx_q + CW'(1);
          end
        end
        ST_WDRAIN: if (!wstage_q && !mem_wr_en) begin
          if (row_end && last_row) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else if (row_end) begin
            row_q   <= row_q + YW'(1);
            xoff_q  <= '0;
            clast_q <= chunk_last(wlen_q);
            st      <= ST_READ;
          end else begin
            xoff_q  <= nxt_off;
            clast_q <= chunk_last(wlen_q - nxt_off);
            st      <= ST_READ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_rd_en && !mem_wr_en && !busy)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd_en && !mem_wr_en)); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(sx_q) && $stable(dx_q) && $stable(wlen_q) && $stable(mask_q))); // R8
endmodule

// File: tb/vram_rect_copy_tb_top.sv
module vram_rect_copy_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] src_word = '0, dst_word = '0, size_word = '0;
  logic        set_mask = 1'b0;
  logic        busy, done, mem_rd_en, mem_wr_en;
  logic [18:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  always #2 clk = ~clk;

  vram_rect_copy dut_i (
    .clk(clk), .rst(rst), .start(start), .src_word(src_word), .dst_word(dst_word),
    .size_word(size_word), .set_mask(set_mask), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [15:0] vram  [int];
  logic [15:0] model [int];
  logic [34:0] exp_q [$];
  int checks = 0, fails = 0, wr_seen = 0, rd_run = 0, max_run = 0;
  bit finished = 0;

  function automatic logic [15:0] seed_val(int a);
    return 16'((a * 13 + (a >>> 3)) & 32'h7FFF);
  endfunction
  function automatic logic [15:0] vram_get(int a);
    return vram.exists(a) ? vram[a] : seed_val(a);
  endfunction
  function automatic logic [15:0] model_get(int a);
    return model.exists(a) ? model[a] : seed_val(a);
  endfunction

  // pixel memory: registered read, one-cycle latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= vram_get(int'(mem_addr));
    if (mem_wr_en) vram[int'(mem_addr)] = mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every write
  always @(negedge clk) if (!rst && !finished) begin
    if (mem_rd_en) rd_run++;
    if (mem_rd_en && mem_wr_en) chk(0, "R10", "read and write together", 1, 0);
    if (mem_wr_en) begin
      if (rd_run > max_run) max_run = rd_run;
      rd_run = 0;
      wr_seen++;
      if (exp_q.size() == 0) chk(0, "R8", "unexpected write", mem_addr, 0);
      else begin
        logic [34:0] e;
        e = exp_q.pop_front();
        chk(mem_addr == e[34:16], "R7", "write address order", mem_addr, e[34:16]);
        chk(mem_wdata == e[15:0], "R4", "write data", mem_wdata, e[15:0]);
      end
    end
  end

  function automatic logic [31:0] pos(int x, int y, bit junk);
    logic [31:0] v;
    v = {7'd0, 9'(y), 6'd0, 10'(x)};
    if (junk) v = v | 32'hFE00_FC00;
    return v;
  endfunction

  // driver: computes expected writes, then runs the copy
  task automatic run_copy(input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] z, input bit m, input bit poke,
                          output int cyc);
    int sx, sy, dx, dy, w, h, n;
    logic [15:0] tmp [128];
    sx = int'(s[9:0]); sy = int'(s[24:16]);
    dx = int'(d[9:0]); dy = int'(d[24:16]);
    w = (z[9:0] == 0) ? 1024 : int'(z[9:0]);
    h = (z[24:16] == 0) ? 512 : int'(z[24:16]);
    if (!(sx == dx && sy == dy && !m)) begin
      for (int r = 0; r < h; r++) begin
        for (int off = 0; off < w; off += 128) begin
          n = (w - off > 128) ? 128 : w - off;
          for (int i = 0; i < n; i++)
            tmp[i] = model_get(((sy + r) % 512) * 1024 + ((sx + off + i) % 1024));
          for (int i = 0; i < n; i++) begin
            int a;
            logic [15:0] v;
            a = ((dy + r) % 512) * 1024 + ((dx + off + i) % 1024);
            v = tmp[i] | (m ? 16'h8000 : 16'h0000);
            model[a] = v;
            exp_q.push_back({19'(a), v});
          end
        end
      end
    end
    @(negedge clk);
    src_word = s; dst_word = d; size_word = z; set_mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (poke && cyc == 20) begin
        chk(busy, "R8", "busy during copy", busy, 1);
        src_word = pos(500, 400, 0); dst_word = pos(3, 3, 0);
        size_word = 32'h0005_0005; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc++;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    chk(done, "R9", "done reached", done, 1);
    chk(exp_q.size() == 0, "R6", "writes outstanding at done", exp_q.size(), 0);
    @(negedge clk);
    chk(!done, "R9", "done lasts one cycle", done, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R9 watchdog expired: actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cyc, w0;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R11", "busy/done after reset", {busy, done}, 0);
    chk(!mem_rd_en && !mem_wr_en, "R11", "requests after reset", {mem_rd_en, mem_wr_en}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1: junk in the ignored bits of both corner words
    w0 = wr_seen;
    run_copy(pos(10, 20, 1), pos(300, 100, 1), 32'h0003_0005, 0, 0, cyc);
    chk(wr_seen - w0 == 15, "R1", "basic write count", wr_seen - w0, 15);

    // R4: mask forced on
    run_copy(pos(40, 41, 0), pos(600, 200, 0), 32'h0002_0004, 1, 0, cyc);

    // R3: both spans wrap at the right and bottom edges
    w0 = wr_seen;
    run_copy(pos(1020, 510, 0), pos(1018, 509, 0), 32'h0004_0008, 0, 0, cyc);
    chk(wr_seen - w0 == 32, "R3", "wrapped write count", wr_seen - w0, 32);

    // R2 + R6: width field 0 means 1024, chunked by 128
    w0 = wr_seen; max_run = 0;
    run_copy(pos(5, 7, 0), pos(0, 480, 0), 32'h0001_0000, 0, 0, cyc);
    chk(wr_seen - w0 == 1024, "R2", "full-width write count", wr_seen - w0, 1024);
    chk(max_run == 128, "R6", "reads per chunk", max_run, 128);

    // R2: height field 0 means 512
    w0 = wr_seen;
    run_copy(pos(900, 100, 0), pos(12, 34, 0), 32'h0000_0002, 0, 0, cyc);
    chk(wr_seen - w0 == 1024, "R2", "full-height write count", wr_seen - w0, 1024);

    // R5: same corner without mask is skipped
    w0 = wr_seen;
    run_copy(pos(77, 88, 0), pos(77, 88, 0), 32'h0004_0004, 0, 0, cyc);
    chk(cyc == 0, "R5", "skip done latency", cyc, 0);
    chk(wr_seen == w0, "R5", "skip issues no writes", wr_seen - w0, 0);

    // R5: same corner with mask is performed
    w0 = wr_seen;
    run_copy(pos(77, 88, 0), pos(77, 88, 0), 32'h0002_0003, 1, 0, cyc);
    chk(wr_seen - w0 == 6, "R5", "masked same-corner writes", wr_seen - w0, 6);

    // R6: source left of overlapping destination
    run_copy(pos(100, 50, 0), pos(150, 50, 0), 32'h0002_012C, 0, 0, cyc);
    // R6: destination left of overlapping source
    run_copy(pos(200, 60, 0), pos(190, 60, 0), 32'h0001_0028, 0, 0, cyc);
    // R7: rows overlap downwards
    run_copy(pos(0, 300, 0), pos(0, 301, 0), 32'h0003_0004, 0, 0, cyc);

    // R8: second start during a copy
    w0 = wr_seen;
    run_copy(pos(10, 150, 0), pos(400, 160, 0), 32'h0002_00C8, 0, 1, cyc);
    repeat (40) @(negedge clk);
    chk(wr_seen - w0 == 400, "R8", "no writes from ignored start", wr_seen - w0, 400);
    chk(!busy, "R8", "idle after ignored start", busy, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule